// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block runs one conversion at a time on an 8-bit serial analog-to-digital converter with a four-way input multiplexer. The converter must receive a short configuration word before every conversion. A client asks for a sample of one channel (0 to 3) through a valid/ready request. The sequencer then pulls chip select low and produces a divided serial clock. It shifts out a 5-bit configuration word, leaves one serial period for the converter to settle, and shifts in eight result bits, most significant bit first. The assembled byte appears on a parallel output together with a one-cycle done pulse.

Each of the four sources is sampled once per frame when the client requests the channels in turn. Outgoing data changes only while the serial clock is low, so the converter can latch it on the rising edge. The converter changes its output after a falling edge, and the sequencer samples that bit on the next rising edge. Both edges are therefore generated and tracked.

All three pins toward the converter are open-drain style. Each output is a pull-down enable: 1 pulls the line low and 0 releases it to the external pull-up. The line level is therefore the inverse of the enable.

The request interface follows these rules. A request transfers on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only when the sequencer is idle. A request held while ready is low simply waits, and it has no effect on a conversion in progress. The result side has no back-pressure: `done_o` pulses for one cycle, and `result_o` holds its value until the next done pulse.

Top module: `adcseq_top`

## Requirements
- R1: After reset, chip select and data-out are released (`csn_pull_o`=0, `mosi_pull_o`=0), the serial clock is held low (`sclk_pull_o`=1), `req_ready_o`=1 and `done_o`=0.
- R2: A request is accepted on an edge with `req_valid_i` and `req_ready_o` both high; from the next cycle `req_ready_o` is low until the sequencer returns to idle.
- R3: In the first 5 serial periods the line levels seen on rising serial edges are, in order, 1, SINGLE_ENDED (default 1), 0, channel bit 1, channel bit 0; data-out changes only while the serial clock is low.
- R4: The 6th serial period is a settling period: the data-in level during it never enters the result.
- R5: Serial periods 7 to 14 carry the result MSB first; the data-in level is sampled on each rising serial edge of those periods.
- R6: After the 14th falling serial edge `done_o` is high for exactly one cycle with the assembled byte on `result_o`, which then holds until the next done pulse.
- R7: Every pin output is a pull-down enable: 1 drives the line low, 0 releases it to logic 1.
- R8: Each chip-select-low window holds exactly 14 rising serial edges; chip select is released together with the done pulse and stays released for at least GAP_PERIODS (default 1) serial periods, during which the serial clock stays low.
- R9: Requests presented while a conversion or gap is in progress are ignored: they start no extra conversion and do not alter the channel in use.
- R10: Each serial clock half-period lasts DIV_HALF (default 2) system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Conversion request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_chan_i | input | CH_BITS (2) | Channel to convert, 0 to 3 |
| sclk_pull_o | output | 1 | Serial clock pull-down enable |
| csn_pull_o | output | 1 | Chip select pull-down enable (1 = selected) |
| mosi_pull_o | output | 1 | Configuration data pull-down enable |
| miso_i | input | 1 | Converter data line level |
| result_o | output | RES_BITS (8) | Last converted sample |
| done_o | output | 1 | One-cycle pulse when `result_o` is updated |

## Verification
The assertions assume that reset is held for a few cycles at start and that `req_chan_i` is stable in the cycle of a handshake. They also assume the converter line `miso_i` is driven only by a well-behaved converter that changes it just after falling serial edges. The bench holds to this: it changes requests only on falling system clock edges, and its converter model updates data-in only on falling serial edges inside the chip-select window. Outside that window the model releases the line high. Requests presented during a busy conversion are driven the same way, so the ignored-request check probes the design's function rather than input timing.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_GAP} seq_state_t;
  localparam int CFG_BITS    = 5;
  localparam int SETTLE_PER  = 1;
endpackage

// File: rtl/adcseq_tick.sv
module adcseq_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i || !run_i || tick_o) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int GAP_PERIODS = 1
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic req_valid_i,
  input  logic tick_i,
  output logic ready_o,
  output logic accept_o,
  output logic run_o,
  output logic selected_o,
  output logic sclk_hi_o,
  output logic fall_o,
  output logic sample_o,
  output logic finish_o
);
  localparam int PERIODS   = CFG_BITS + SETTLE_PER + RES_BITS;
  localparam int PW        = $clog2(PERIODS);
  localparam int GAP_TICKS = 2 * GAP_PERIODS;
  localparam int GW        = $clog2(GAP_TICKS + 1);

  seq_state_t    state_q;
  logic          sclk_hi_q;
  logic [PW-1:0] period_q;
  logic [GW-1:0] gap_q;
  logic          rise;

  assign ready_o    = (state_q == ST_IDLE);
  assign accept_o   = ready_o && req_valid_i;
  assign run_o      = (state_q != ST_IDLE);
  assign selected_o = (state_q == ST_ACTIVE);
  assign sclk_hi_o  = sclk_hi_q;
  assign rise       = selected_o && tick_i && !sclk_hi_q;
  assign fall_o     = selected_o && tick_i && sclk_hi_q;
  assign sample_o   = rise && (period_q >= PW'(CFG_BITS + SETTLE_PER));
  assign finish_o   = fall_o && (period_q == PW'(PERIODS - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      state_q   <= ST_IDLE;
      sclk_hi_q <= 1'b0;
      period_q  <= '0;
      gap_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q   <= ST_ACTIVE;
          sclk_hi_q <= 1'b0;
          period_q  <= '0;
        end
        ST_ACTIVE: if (tick_i) begin
          if (!sclk_hi_q) begin
            sclk_hi_q <= 1'b1;
          end else begin
            sclk_hi_q <= 1'b0;
            if (finish_o) begin
              state_q <= ST_GAP;
              gap_q   <= '0;
            end else begin
              period_q <= period_q + 1'b1;
            end
          end
        end
        ST_GAP: if (tick_i) begin
          if (gap_q == GW'(GAP_TICKS - 1)) state_q <= ST_IDLE;
          else                             gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_shift.sv
module adcseq_shift
  import adcseq_pkg::*;
#(
  parameter int CH_BITS      = 2,
  parameter int RES_BITS     = 8,
  parameter bit SINGLE_ENDED = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                load_i,
  input  logic [CH_BITS-1:0]  chan_i,
  input  logic                fall_i,
  input  logic                sample_i,
  input  logic                finish_i,
  input  logic                miso_i,
  output logic                dout_lvl_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);
  logic [CFG_BITS-1:0] cfg_word;
  logic [CFG_BITS-1:0] cfg_q;
  logic [RES_BITS-1:0] res_q;

  always_comb begin
    cfg_word                 = '0;
    cfg_word[CFG_BITS-1]     = 1'b1;
    cfg_word[CFG_BITS-2]     = SINGLE_ENDED;
    cfg_word[CH_BITS-1:0]    = chan_i;
  end

  assign dout_lvl_o = cfg_q[CFG_BITS-1];

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cfg_q    <= '1;
      res_q    <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
    end else begin
      if (load_i)      cfg_q <= cfg_word;
      else if (fall_i) cfg_q <= {cfg_q[CFG_BITS-2:0], 1'b1};
      if (sample_i)    res_q <= {res_q[RES_BITS-2:0], miso_i};
      if (finish_i)    result_o <= res_q;
      done_o <= finish_i;
    end
  end
endmodule

// File: rtl/adcseq_odpad.sv
module adcseq_odpad #(
  parameter int N = 3
) (
  input  logic [N-1:0] level_i,
  output logic [N-1:0] pull_o
);
  for (genvar i = 0; i < N; i++) begin : g_pad
    assign pull_o[i] = ~level_i[i];
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int DIV_HALF     = 2,
  parameter int GAP_PERIODS  = 1,
  parameter int CH_BITS      = 2,
  parameter int RES_BITS     = 8,
  parameter bit SINGLE_ENDED = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [CH_BITS-1:0]  req_chan_i,
  output logic                sclk_pull_o,
  output logic                csn_pull_o,
  output logic                mosi_pull_o,
  input  logic                miso_i,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);
  logic tick, accept, run, selected, sclk_hi, fall, sample, finish, dout_lvl;
  logic [2:0] pad_pull;

  adcseq_tick #(.DIV_HALF(DIV_HALF)) tick_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .run_i(run), .tick_o(tick)
  );

  adcseq_ctrl #(.RES_BITS(RES_BITS), .GAP_PERIODS(GAP_PERIODS)) ctrl_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .req_valid_i(req_valid_i), .tick_i(tick),
    .ready_o(req_ready_o), .accept_o(accept), .run_o(run), .selected_o(selected),
    .sclk_hi_o(sclk_hi), .fall_o(fall), .sample_o(sample), .finish_o(finish)
  );

  adcseq_shift #(.CH_BITS(CH_BITS), .RES_BITS(RES_BITS), .SINGLE_ENDED(SINGLE_ENDED)) shift_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .load_i(accept), .chan_i(req_chan_i),
    .fall_i(fall), .sample_i(sample), .finish_i(finish), .miso_i(miso_i),
    .dout_lvl_o(dout_lvl), .result_o(result_o), .done_o(done_o)
  );

  adcseq_odpad #(.N(3)) pad_i (
    .level_i({sclk_hi, ~selected, dout_lvl}),
    .pull_o(pad_pull)
  );

  assign sclk_pull_o = pad_pull[2];
  assign csn_pull_o  = pad_pull[1];
  assign mosi_pull_o = pad_pull[0];
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int DIV_HALF = 2,
  parameter int RES_BITS = 8
) (
  input logic                clk_i,
  input logic                rst_n_i,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic                sclk_pull_o,
  input logic                csn_pull_o,
  input logic                mosi_pull_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                done_o
);
  logic [15:0] hold_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i)                   hold_q <= 16'd0;
    else if (!$stable(sclk_pull_o)) hold_q <= 16'd1;
    else if (hold_q != 16'hFFFF)    hold_q <= hold_q + 16'd1;
  end

  assert_accept_drops_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    csn_pull_o |-> !req_ready_o);

  assert_dout_moves_low_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(mosi_pull_o) |-> sclk_pull_o);

  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> !done_o);

  assert_result_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !done_o |-> $stable(result_o));

  assert_idle_clock_low_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !csn_pull_o |-> sclk_pull_o);

  assert_release_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(csn_pull_o) |-> done_o);

  assert_half_period_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(sclk_pull_o) |-> (hold_q == 16'(DIV_HALF)));
endmodule

bind adcseq_top adcseq_chk #(.DIV_HALF(DIV_HALF), .RES_BITS(RES_BITS)) chk_i (
  .clk_i(clk_i), .rst_n_i(rst_n_i), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .sclk_pull_o(sclk_pull_o), .csn_pull_o(csn_pull_o), .mosi_pull_o(mosi_pull_o),
  .result_o(result_o), .done_o(done_o)
);

// File: tb/adcseq_top_tb_top.sv
module adcseq_top_tb_top;
  localparam int DIV_HALF = 2;
  localparam int GAP_PER  = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_chan = 2'd0;
  logic       req_ready, sclk_pull, csn_pull, mosi_pull, done;
  logic       miso = 1'b1;
  logic [7:0] result;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  adcseq_top #(.DIV_HALF(DIV_HALF), .GAP_PERIODS(GAP_PER)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_chan_i(req_chan), .sclk_pull_o(sclk_pull), .csn_pull_o(csn_pull),
    .mosi_pull_o(mosi_pull), .miso_i(miso), .result_o(result), .done_o(done)
  );

  // converter model: line levels are the inverse of the pull enables
  logic [7:0] chan_val [4];
  logic [4:0] cfg_cap;
  int rcnt = 0, fcnt = 0, frames = 0;

  always @(posedge csn_pull) begin rcnt = 0; fcnt = 0; cfg_cap = '0; frames++; end
  always @(negedge csn_pull) miso = 1'b1;
  always @(negedge sclk_pull) if (csn_pull) begin
    rcnt++;
    if (rcnt <= 5) cfg_cap = {cfg_cap[3:0], ~mosi_pull};
  end
  always @(posedge sclk_pull) if (csn_pull) begin
    fcnt++;
    if (fcnt == 5) miso = 1'b0;                     // settle period: misleading level
    else if (fcnt >= 6 && fcnt <= 13) miso = chan_val[cfg_cap[1:0]][13 - fcnt];
  end

  // high-half length monitor
  int hi_run = 0, hi_min = 1000, hi_max = 0;
  always @(negedge clk) begin
    if (!sclk_pull) hi_run++;
    else if (hi_run != 0) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int waited);
    waited = 0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(csn_pull == 1'b0, "R1 cs released", csn_pull, 0);
    check(mosi_pull == 1'b0, "R1 dout released", mosi_pull, 0);
    check(sclk_pull == 1'b1, "R7 sclk held low by pull enable", sclk_pull, 1);
    check(req_ready == 1'b1 && done == 1'b0, "R1 ready/done", {req_ready, done}, 2);
  endtask

  task automatic t_convert(input logic [1:0] ch, input logic [7:0] val);
    int w;
    chan_val[ch] = val;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = ch;
    @(negedge clk);
    req_valid = 1'b0; req_chan = ~ch;
    check(req_ready == 1'b0, "R2 ready low after accept", req_ready, 0);
    check(csn_pull == 1'b1, "R7 cs pulled low", csn_pull, 1);
    wait_done(w);
    check(done == 1'b1, "R6 done seen", done, 1);
    check(result == val, "R5 result MSB first / R4 settle ignored", result, val);
    check(cfg_cap == {3'b110, ch}, "R3 config word", cfg_cap, {3'b110, ch});
    check(rcnt == 14, "R8 rising edges per window", rcnt, 14);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
    check(result == val, "R6 result holds", result, val);
  endtask

  task automatic t_busy_ignored();
    int w, f0;
    chan_val[1] = 8'h5A; chan_val[3] = 8'hC3;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    f0 = frames;
    req_valid = 1'b1; req_chan = 2'd1;
    @(negedge clk);
    req_chan = 2'd3;                               // held while busy
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_done(w);
    check(result == 8'h5A, "R9 channel unchanged by busy request", result, 8'h5A);
    repeat (30) @(negedge clk);
    check(frames == f0 + 1 && csn_pull == 1'b0, "R9 no extra conversion", frames - f0, 1);
  endtask

  task automatic t_gap();
    int w, gap;
    chan_val[2] = 8'h81;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_chan = 2'd2;
    @(negedge clk);
    wait_done(w);
    gap = 0;
    while (!csn_pull && gap < 100) begin @(negedge clk); gap++; end
    req_valid = 1'b0;
    check(gap >= 2 * DIV_HALF * GAP_PER, "R8 chip select gap", gap, 2 * DIV_HALF * GAP_PER);
    wait_done(w);
    check(result == 8'h81, "R8 back-to-back result", result, 8'h81);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_convert(2'd0, 8'hA5);
    t_convert(2'd1, 8'h3C);
    t_convert(2'd2, 8'h81);
    t_convert(2'd3, 8'h7E);
    t_convert(2'd0, 8'h00);
    t_convert(2'd3, 8'hFF);
    t_busy_ignored();
    t_gap();
    check(hi_min == DIV_HALF && hi_max == DIV_HALF, "R10 half period", hi_max, DIV_HALF);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule